// File: doc/BRIEF.md
# Fast Kernel-to-User Return State Unit

This unit performs the state update for a fast return from privileged kernel code to unprivileged user code. A request carries the current privilege level, the protection-enable bit, the execution-mode flags (real, virtual-8086, 64-bit), a flag for a bus-lock prefix on the instruction, the programmed kernel code-segment selector, and two general-purpose register values. One of these registers supplies the new stack pointer and the other supplies the new instruction pointer.

The unit first checks the request against the privilege and mode rules. If a rule is broken, it reports a fault class. If the request is legal, it returns the full code-segment and stack-segment state. Both segments are flat and have fixed attributes. Their selectors are taken at fixed offsets from the programmed selector. The unit also returns the new privilege level, the stack pointer and the instruction pointer. The surrounding pipeline writes this result into the architectural registers.

Each request is a single-cycle strobe. Its result appears on a done pulse one clock later.

Top module: `fast_user_return`

## Requirements
- R1: The `done` output pulses for exactly one cycle, in the cycle after each `req_valid` cycle. All other outputs change only at that point and hold their values between requests.
- R2: When `lock_pfx` is set, the result is a fault with class 2'b01 (invalid opcode). This class wins over every general-protection condition.
- R3: Without a lock prefix, the result is a fault with class 2'b10 (general protection, error code 0) in any of these cases: `kcs_sel[15:2]` is zero, `pe_in` is 0, `mode_real` is set, or `cpl_in` is not 0.
- R4: Without a lock prefix, setting `mode_v86` always gives fault class 2'b10, even when every other input is legal.
- R5: When `mode_long` is set, fault class 2'b10 is raised if either `sp_src` or `ip_src` is non-canonical. An address is canonical when its bits 63:47 are all equal. Outside 64-bit mode, no canonical check is made.
- R6: On success, `cs_sel` is `kcs_sel + 16` and `ss_sel` is `kcs_sel + 24`. Both sums wrap modulo 2^16, and bits 1:0 of each selector are forced to 2'b11.
- R7: On success, both segments have base 0 and limit 20'hFFFFF. Each attribute word is laid out MSB first as {G, D, P, DPL[1:0], S, TYPE[3:0]}. In both segments G, D, P and S are 1 and DPL is 3.
- R8: The code segment has TYPE 4'b1011 and the stack segment has TYPE 4'b0011. This makes `cs_attr` 10'h3FB and `ss_attr` 10'h3F3.
- R9: On success, `new_cpl` is 3, `new_sp` comes from `sp_src` and `new_ip` comes from `ip_src`. Outside 64-bit mode, only the low 32 bits are kept and the upper bits are zero.
- R10: A successful result gives `fault_valid` 0 and `fault_class` 2'b00. A faulting result gives `fault_valid` 1, and every segment, privilege and pointer output is zero.
- R11: After reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| cpl_in | input | 2 | Current privilege level |
| pe_in | input | 1 | Protection enabled |
| mode_real | input | 1 | Real-address mode |
| mode_v86 | input | 1 | Virtual-8086 mode |
| mode_long | input | 1 | 64-bit mode |
| lock_pfx | input | 1 | Lock prefix present on the instruction |
| kcs_sel | input | 16 | Programmed kernel code-segment selector |
| sp_src | input | 64 | Source of the new stack pointer |
| ip_src | input | 64 | Source of the new instruction pointer |
| done | output | 1 | Result pulse |
| fault_valid | output | 1 | Result is a fault |
| fault_class | output | 2 | 00 none, 01 invalid opcode, 10 general protection |
| cs_sel | output | 16 | New code-segment selector |
| cs_base | output | 32 | New code-segment base |
| cs_limit | output | 20 | New code-segment limit |
| cs_attr | output | 10 | New code-segment attributes {G,D,P,DPL,S,TYPE} |
| ss_sel | output | 16 | New stack-segment selector |
| ss_base | output | 32 | New stack-segment base |
| ss_limit | output | 20 | New stack-segment limit |
| ss_attr | output | 10 | New stack-segment attributes {G,D,P,DPL,S,TYPE} |
| new_cpl | output | 2 | New privilege level |
| new_sp | output | 64 | New stack pointer |
| new_ip | output | 64 | New instruction pointer |

## Verification
Legal returns are driven in both legacy and 64-bit mode with pointers whose upper bits are set. This tells zero-extension apart from pass-through, and shows whether the canonical test looks at the right bit range. Each fault condition is driven alone. The lock prefix is then combined with every general-protection cause, so that a wrong priority shows up in the class. Selector boundary values are driven as well: bits 15:2 just zero versus just nonzero, and a selector near 16'hFFFF. These expose a wrong null test, a missing RPL force and a missing wrap. Back-to-back requests followed by idle gaps separate the single-pulse timing from the hold behaviour, and a random mix covers the remaining combinations.

// File: rtl/fur_pkg.sv
package fur_pkg;
  parameter int SEL_W    = 16;
  parameter int GPR_W    = 64;
  parameter int VA_BITS  = 48;
  parameter int NARROW_W = 32;
  parameter int BASE_W   = 32;
  parameter int LIM_W    = 20;
  parameter int TYPE_W   = 4;
  parameter int ATTR_W   = TYPE_W + 6;
  parameter int CS_OFS   = 16;
  parameter int SS_OFS   = 24;

  parameter logic [1:0]        USER_PL    = 2'd3;
  parameter logic [1:0]        KERNEL_PL  = 2'd0;
  parameter logic [TYPE_W-1:0] CODE_TYPE  = 4'b1011;
  parameter logic [TYPE_W-1:0] STACK_TYPE = 4'b0011;
  parameter logic [LIM_W-1:0]  FLAT_LIMIT = '1;

  typedef enum logic [1:0] {
    FC_NONE = 2'd0,
    FC_UD   = 2'd1,
    FC_GP   = 2'd2
  } fault_class_e;

  typedef struct packed {
    logic [SEL_W-1:0]  sel;
    logic [BASE_W-1:0] base;
    logic [LIM_W-1:0]  limit;
    logic [ATTR_W-1:0] attr;
  } seg_state_t;

  // Attribute word, MSB first: G, D, P, DPL, S, TYPE
  function automatic logic [ATTR_W-1:0] pack_attr(
    input logic g, input logic d, input logic p,
    input logic [1:0] dpl, input logic s, input logic [TYPE_W-1:0] ty);
    return {g, d, p, dpl, s, ty};
  endfunction

  // Selector at a fixed offset from the programmed one, RPL forced to user
  function automatic logic [SEL_W-1:0] user_selector(
    input logic [SEL_W-1:0] k, input int unsigned ofs);
    logic [SEL_W-1:0] sum;
    sum = k + SEL_W'(ofs);
    return {sum[SEL_W-1:2], USER_PL};
  endfunction

  // Canonical: all bits from VA_BITS-1 upward agree
  function automatic logic addr_canonical(input logic [GPR_W-1:0] a);
    logic [GPR_W-VA_BITS:0] hi;
    hi = a[GPR_W-1:VA_BITS-1];
    return (&hi) | ~(|hi);
  endfunction

  function automatic logic [GPR_W-1:0] pointer_value(
    input logic [GPR_W-1:0] a, input logic wide);
    return wide ? a : {{(GPR_W-NARROW_W){1'b0}}, a[NARROW_W-1:0]};
  endfunction
endpackage

// File: rtl/fur_fault_check.sv
module fur_fault_check
  import fur_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        cpl,
  input  logic              pe,
  input  logic              mode_real,
  input  logic              mode_v86,
  input  logic              mode_long,
  input  logic              lock_pfx,
  input  logic [SEL_W-1:0]  kcs_sel,
  input  logic [GPR_W-1:0]  sp_src,
  input  logic [GPR_W-1:0]  ip_src,
  output logic              fault_any,
  output fault_class_e      fault_class
);
  // Individual rule hits, named for the assertions
  logic hit_lock, hit_sel_null, hit_prot_off, hit_priv, hit_v86, hit_noncanon;
  logic gp_any;

  always_comb begin
    hit_lock     = lock_pfx;
    hit_sel_null = ~(|kcs_sel[SEL_W-1:2]);
    hit_prot_off = ~pe | mode_real;
    hit_priv     = (cpl != KERNEL_PL);
    hit_v86      = mode_v86;
    hit_noncanon = mode_long & ~(addr_canonical(sp_src) & addr_canonical(ip_src));
    gp_any       = hit_sel_null | hit_prot_off | hit_priv | hit_v86 | hit_noncanon;
  end

  // Invalid opcode outranks all protection causes
  always_comb begin
    if (hit_lock)     fault_class = FC_UD;
    else if (gp_any)  fault_class = FC_GP;
    else              fault_class = FC_NONE;
    fault_any = (fault_class != FC_NONE);
  end

  assert_lock_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && lock_pfx |-> fault_class == FC_UD);
  assert_v86_faults_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && mode_v86 && !lock_pfx |-> fault_class == FC_GP);
  assert_priv_faults_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !lock_pfx && (cpl != 2'd0) |-> fault_any);
endmodule

// File: rtl/fur_seg_build.sv
module fur_seg_build
  import fur_pkg::*;
#(
  parameter bit IS_CODE = 1'b1,
  parameter int OFFSET  = CS_OFS
) (
  input  logic [SEL_W-1:0] kcs_sel,
  output seg_state_t       seg
);
  logic [TYPE_W-1:0] seg_type;

  generate
    if (IS_CODE) begin : g_code
      assign seg_type = CODE_TYPE;
    end else begin : g_stack
      assign seg_type = STACK_TYPE;
    end
  endgenerate

  always_comb begin
    seg.sel   = user_selector(kcs_sel, OFFSET);
    seg.base  = '0;
    seg.limit = FLAT_LIMIT;
    seg.attr  = pack_attr(1'b1, 1'b1, 1'b1, USER_PL, 1'b1, seg_type);
  end
endmodule

// File: rtl/fast_user_return.sv
module fast_user_return
  import fur_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [1:0]         cpl_in,
  input  logic               pe_in,
  input  logic               mode_real,
  input  logic               mode_v86,
  input  logic               mode_long,
  input  logic               lock_pfx,
  input  logic [15:0]        kcs_sel,
  input  logic [63:0]        sp_src,
  input  logic [63:0]        ip_src,
  output logic               done,
  output logic               fault_valid,
  output logic [1:0]         fault_class,
  output logic [15:0]        cs_sel,
  output logic [31:0]        cs_base,
  output logic [19:0]        cs_limit,
  output logic [9:0]         cs_attr,
  output logic [15:0]        ss_sel,
  output logic [31:0]        ss_base,
  output logic [19:0]        ss_limit,
  output logic [9:0]         ss_attr,
  output logic [1:0]         new_cpl,
  output logic [63:0]        new_sp,
  output logic [63:0]        new_ip
);
  fault_class_e  chk_class;
  logic          chk_fault;
  seg_state_t    cs_next, ss_next;
  logic [GPR_W-1:0] sp_next, ip_next;

  fur_fault_check u_check (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .cpl        (cpl_in),
    .pe         (pe_in),
    .mode_real  (mode_real),
    .mode_v86   (mode_v86),
    .mode_long  (mode_long),
    .lock_pfx   (lock_pfx),
    .kcs_sel    (kcs_sel),
    .sp_src     (sp_src),
    .ip_src     (ip_src),
    .fault_any  (chk_fault),
    .fault_class(chk_class)
  );

  fur_seg_build #(.IS_CODE(1'b1), .OFFSET(CS_OFS)) u_cs (
    .kcs_sel(kcs_sel), .seg(cs_next));
  fur_seg_build #(.IS_CODE(1'b0), .OFFSET(SS_OFS)) u_ss (
    .kcs_sel(kcs_sel), .seg(ss_next));

  always_comb begin
    sp_next = pointer_value(sp_src, mode_long);
    ip_next = pointer_value(ip_src, mode_long);
  end

  seg_state_t cs_q, ss_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done        <= 1'b0;
      fault_valid <= 1'b0;
      fault_class <= FC_NONE;
      cs_q        <= '0;
      ss_q        <= '0;
      new_cpl     <= '0;
      new_sp      <= '0;
      new_ip      <= '0;
    end else begin
      done <= req_valid;
      if (req_valid) begin
        fault_valid <= chk_fault;
        fault_class <= chk_class;
        if (chk_fault) begin
          cs_q    <= '0;
          ss_q    <= '0;
          new_cpl <= '0;
          new_sp  <= '0;
          new_ip  <= '0;
        end else begin
          cs_q    <= cs_next;
          ss_q    <= ss_next;
          new_cpl <= USER_PL;
          new_sp  <= sp_next;
          new_ip  <= ip_next;
        end
      end
    end
  end

  assign cs_sel   = cs_q.sel;
  assign cs_base  = cs_q.base;
  assign cs_limit = cs_q.limit;
  assign cs_attr  = cs_q.attr;
  assign ss_sel   = ss_q.sel;
  assign ss_base  = ss_q.base;
  assign ss_limit = ss_q.limit;
  assign ss_attr  = ss_q.attr;

  assert_done_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> done);
  assert_done_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !done);
  assert_hold_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(new_sp) && $stable(new_ip) && $stable(cs_sel));
  assert_sel_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done && !fault_valid |-> ss_sel[15:2] == cs_sel[15:2] + 14'd2);
  assert_user_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done && !fault_valid |-> new_cpl == 2'd3 && cs_sel[1:0] == 2'd3 && ss_sel[1:0] == 2'd3);
  assert_fault_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done && fault_valid |-> new_sp == '0 && new_ip == '0 && cs_attr == '0 && ss_attr == '0);
  assert_class_matches_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (fault_valid == (fault_class != 2'd0)));
endmodule

// File: tb/fast_user_return_test.sv
module fast_user_return_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        req_valid = 0, pe_in = 0, mode_real = 0, mode_v86 = 0, mode_long = 0, lock_pfx = 0;
  logic [1:0]  cpl_in = 0;
  logic [15:0] kcs_sel = 0;
  logic [63:0] sp_src = 0, ip_src = 0;
  logic        done, fault_valid;
  logic [1:0]  fault_class, new_cpl;
  logic [15:0] cs_sel, ss_sel;
  logic [31:0] cs_base, ss_base;
  logic [19:0] cs_limit, ss_limit;
  logic [9:0]  cs_attr, ss_attr;
  logic [63:0] new_sp, new_ip;

  fast_user_return uut (.*);

  typedef struct {
    string       tag;
    logic        fv;
    logic [1:0]  cls;
    logic [15:0] css, sss;
    logic [31:0] base;
    logic [19:0] lim;
    logic [9:0]  csa, ssa;
    logic [1:0]  cpl;
    logic [63:0] sp, ip;
  } exp_t;

  exp_t exq[$];
  exp_t last_exp;
  bit   have_last = 0;
  int   n_checks = 0, n_fails = 0;
  bit   reported = 0;

  task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic bit noncanon(logic [63:0] a);
    logic signed [63:0] ext;
    ext = {{16{a[47]}}, a[47:0]};
    return ext != a;
  endfunction

  function automatic exp_t model(string tag, logic [1:0] cpl, logic pe, logic rm, logic v86,
                                 logic lm, logic lk, logic [15:0] k, logic [63:0] sp, logic [63:0] ip);
    exp_t e;
    bit gp;
    e.tag = tag;
    gp = v86 || rm || !pe || cpl != 2'd0 || k[15:2] == 14'd0 || (lm && (noncanon(sp) || noncanon(ip)));
    e.fv = lk || gp;
    e.cls = lk ? 2'b01 : (gp ? 2'b10 : 2'b00);
    if (e.fv) begin
      e.css = 0; e.sss = 0; e.base = 0; e.lim = 0; e.csa = 0; e.ssa = 0;
      e.cpl = 0; e.sp = 0; e.ip = 0;
    end else begin
      e.css = {k[15:2] + 14'd4, 2'b11};
      e.sss = {k[15:2] + 14'd6, 2'b11};
      e.base = 0; e.lim = 20'hFFFFF;
      e.csa = 10'h3FB; e.ssa = 10'h3F3;
      e.cpl = 2'd3;
      e.sp = lm ? sp : {32'd0, sp[31:0]};
      e.ip = lm ? ip : {32'd0, ip[31:0]};
    end
    return e;
  endfunction

  task automatic send(string tag, logic [1:0] cpl, logic pe, logic rm, logic v86, logic lm,
                      logic lk, logic [15:0] k, logic [63:0] sp, logic [63:0] ip);
    @(negedge clk);
    cpl_in = cpl; pe_in = pe; mode_real = rm; mode_v86 = v86; mode_long = lm;
    lock_pfx = lk; kcs_sel = k; sp_src = sp; ip_src = ip; req_valid = 1;
    exq.push_back(model(tag, cpl, pe, rm, v86, lm, lk, k, sp, ip));
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 0;
      sp_src = 64'hDEAD_BEEF_0BAD_F00D;
      ip_src = 64'h1234_5678_9ABC_DEF0;
      kcs_sel = 16'h5A5C;
    end
  endtask

  // Monitor: compare each result against the front of the scoreboard
  always @(negedge clk) begin
    if (rst_n && !reported) begin
      if (done) begin
        if (exq.size() == 0) begin
          chk(0, "R1", "done without request", 64'(done), 64'd0);
        end else begin
          exp_t e;
          e = exq.pop_front();
          chk(fault_valid == e.fv, e.tag, "fault_valid", 64'(fault_valid), 64'(e.fv));
          chk(fault_class == e.cls, e.tag, "fault_class", 64'(fault_class), 64'(e.cls));
          chk(cs_sel == e.css, e.tag, "cs_sel", 64'(cs_sel), 64'(e.css));
          chk(ss_sel == e.sss, e.tag, "ss_sel", 64'(ss_sel), 64'(e.sss));
          chk(cs_base == e.base && ss_base == e.base, e.tag, "base",
              {cs_base, ss_base}, {e.base, e.base});
          chk(cs_limit == e.lim && ss_limit == e.lim, e.tag, "limit",
              {cs_limit, ss_limit}, {e.lim, e.lim});
          chk(cs_attr == e.csa, e.tag, "cs_attr", 64'(cs_attr), 64'(e.csa));
          chk(ss_attr == e.ssa, e.tag, "ss_attr", 64'(ss_attr), 64'(e.ssa));
          chk(new_cpl == e.cpl, e.tag, "new_cpl", 64'(new_cpl), 64'(e.cpl));
          chk(new_sp == e.sp, e.tag, "new_sp", new_sp, e.sp);
          chk(new_ip == e.ip, e.tag, "new_ip", new_ip, e.ip);
          last_exp = e;
          have_last = 1;
        end
      end else if (have_last) begin
        // R1: outputs hold between requests
        chk(new_sp == last_exp.sp && new_ip == last_exp.ip && cs_sel == last_exp.css,
            "R1", "hold", new_sp, last_exp.sp);
      end
    end
  end

  task automatic finish_run();
    if (!reported) begin
      reported = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    #(5 * 150000);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    // R11: reset state
    chk(done == 0 && fault_valid == 0 && fault_class == 0, "R11", "status", 64'({done, fault_valid, fault_class}), 0);
    chk(cs_sel == 0 && ss_sel == 0 && cs_attr == 0 && cs_limit == 0, "R11", "segments",
        64'({cs_sel, ss_sel}), 0);
    chk(new_sp == 0 && new_ip == 0 && new_cpl == 0, "R11", "pointers", new_sp | new_ip, 0);
    rst_n = 1;
    idle(2);

    // R6 R7 R8 R9: legal legacy return, upper pointer bits dropped
    send("R9", 2'd0, 1, 0, 0, 0, 0, 16'h0010, 64'hFFFF_0000_0040_1000, 64'hAAAA_BBBB_0804_8000);
    idle(3);
    // R5 R9: legal 64-bit return with high canonical addresses
    send("R5", 2'd0, 1, 0, 0, 1, 0, 16'h0023, 64'hFFFF_8000_0000_1234, 64'h0000_7FFF_FFFF_F000);
    // R5: non-canonical stack source in 64-bit mode
    send("R5", 2'd0, 1, 0, 0, 1, 0, 16'h0020, 64'h0000_8000_0000_0000, 64'h0000_0000_0040_0000);
    // R5: non-canonical instruction source in 64-bit mode
    send("R5", 2'd0, 1, 0, 0, 1, 0, 16'h0020, 64'h0, 64'h8000_0000_0000_0000);
    // R5: same pattern outside 64-bit mode is legal
    send("R5", 2'd0, 1, 0, 0, 0, 0, 16'h0020, 64'h0000_8000_0000_0000, 64'h8000_0000_0000_0004);
    idle(2);
    // R3: null selector boundary, then smallest non-null
    send("R3", 2'd0, 1, 0, 0, 0, 0, 16'h0003, 64'h10, 64'h20);
    send("R3", 2'd0, 1, 0, 0, 0, 0, 16'h0004, 64'h10, 64'h20);
    // R3: privilege not kernel, protection off, real mode
    send("R3", 2'd3, 1, 0, 0, 0, 0, 16'h0008, 64'h10, 64'h20);
    send("R3", 2'd1, 1, 0, 0, 0, 0, 16'h0008, 64'h10, 64'h20);
    send("R3", 2'd0, 0, 0, 0, 0, 0, 16'h0008, 64'h10, 64'h20);
    send("R3", 2'd0, 1, 1, 0, 0, 0, 16'h0008, 64'h10, 64'h20);
    // R4: virtual-8086 with otherwise legal inputs
    send("R4", 2'd0, 1, 0, 1, 0, 0, 16'h0008, 64'h10, 64'h20);
    idle(1);
    // R2: lock prefix alone and with each protection cause
    send("R2", 2'd0, 1, 0, 0, 0, 1, 16'h0008, 64'h10, 64'h20);
    send("R2", 2'd3, 0, 1, 1, 1, 1, 16'h0000, 64'h0000_8000_0000_0000, 64'h20);
    send("R2", 2'd0, 1, 0, 1, 0, 1, 16'h0008, 64'h10, 64'h20);
    send("R2", 2'd2, 1, 0, 0, 0, 1, 16'h0001, 64'h10, 64'h20);
    // R6: selector wrap near the top of the range
    send("R6", 2'd0, 1, 0, 0, 0, 0, 16'hFFF8, 64'h1, 64'h2);
    send("R6", 2'd0, 1, 0, 0, 1, 0, 16'hFFEF, 64'h3, 64'h4);
    // R10: fault after success clears state
    send("R10", 2'd0, 1, 0, 0, 0, 0, 16'h0010, 64'h55, 64'h66);
    send("R10", 2'd1, 1, 0, 0, 0, 0, 16'h0010, 64'h55, 64'h66);
    idle(3);

    // Random mix
    for (int i = 0; i < 200; i++) begin
      logic [31:0] r;
      logic [63:0] s, p;
      r = $urandom;
      s = {$urandom, $urandom};
      p = {$urandom, $urandom};
      if (r[20]) s = {{16{s[47]}}, s[47:0]};
      if (r[21]) p = {{16{p[47]}}, p[47:0]};
      send("R10", (r[1:0] == 2'd0 || r[2]) ? 2'd0 : r[1:0], ~(r[3] & r[4]), r[5] & r[6] & r[7],
           r[8] & r[9] & r[10], r[11], r[12] & r[13] & r[14], r[31:16], s, p);
      if (r[15]) idle(1);
    end
    idle(4);
    chk(exq.size() == 0, "R1", "results outstanding", 64'(exq.size()), 0);
    finish_run();
  end
endmodule